// File: doc/BRIEF.md
# Trap Arbiter and Trap-State Update Unit

This unit decides, once per clock, whether the hart has to take a trap, and it updates the trap state of the chosen privilege level. Its inputs are the current privilege, the pending-interrupt word, the two delegation words (one for interrupts, one for exceptions), the interrupt-enable bits and stacked status bits, the two trap-vector bases, the current PC and a synchronous exception request. The exception request carries a cause number and may carry a faulting address.

Interrupt eligibility is settled in two stages. Interrupts that are not delegated are tried first, under the machine-level enable rule. Only when none of them is eligible are delegated interrupts tried, under the supervisor-level enable rule. The lowest-numbered eligible bit wins. A synchronous exception always wins over any interrupt presented in the same cycle. The accepted trap goes to supervisor or machine level according to the delegation word for its kind.

All results (new PC, new privilege, status stack, cause, exception PC, bad address) are registered and commit on one clock edge. `trapFire` pulses in the cycle that follows the request. The surrounding core loads the registered values when it sees that pulse.

Top module: `trap_unit`

## Requirements
- R1: Privilege encoding is user 2'b00, supervisor 2'b01, machine 2'b11. A pending bit whose interrupt-delegation bit is clear is eligible when the privilege is below machine, or when it is machine and `inMie` is 1.
- R2: Delegated pending bits are considered only when no bit is eligible under R1. They are eligible when the privilege is user, or when it is supervisor and `inSie` is 1, so they are never taken in machine mode.
- R3: Among the eligible interrupts the lowest index wins. The recorded cause is that index with bit XLEN-1 set.
- R4: A valid exception request takes precedence over any interrupt in the same cycle. Its cause is recorded unchanged, with bit XLEN-1 clear.
- R5: A trap goes to supervisor only when the prior privilege is user or supervisor, the cause index is below XLEN, and the cause's bit is set in the delegation word of its kind (`midelegIn` for interrupts, `medelegIn` for exceptions). Every other trap goes to machine.
- R6: On a supervisor trap: `stSpie` takes the old `inSie`, `stSpp` takes bit 0 of the prior privilege, `stSie` is cleared, `privOut` becomes supervisor, `nextPc` is `stvecIn`, and `sepcOut`/`scauseOut` take `curPc` and the cause. Machine-level status bits pass through from their inputs.
- R7: On a machine trap, `nextPc` is `mtvecIn` with bit 0 cleared. When bit 0 of `mtvecIn` is 1 and the trap is an interrupt, 4 times the cause index is added to it.
- R8: On a machine trap: `stMpie` takes the old `inMie`, `stMpp` takes the prior privilege, `stMie` is cleared, `privOut` becomes machine, and `mepcOut`/`mcauseOut` take `curPc` and the cause. Supervisor-level status bits pass through from their inputs.
- R9: The target level's bad-address register takes `excTval` only when an exception is taken with `excTvalValid` set. Interrupts never write it, and the other level's register is never written.
- R10: All outputs are registered. `trapFire` is 1 exactly in the cycle after a cycle with a request and 0 otherwise. Between traps, and for the level not targeted, the registered values hold.
- R11: During reset `trapFire` and `trapToSuper` are 0, `privOut` is machine, and every other output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| curPriv | input | 2 | Current privilege level |
| curPc | input | XLEN | PC saved as exception PC |
| irqPending | input | XLEN | Pending interrupt bits |
| midelegIn | input | XLEN | Interrupt delegation word |
| medelegIn | input | XLEN | Exception delegation word |
| mtvecIn | input | XLEN | Machine trap vector, bit 0 selects vectored mode |
| stvecIn | input | XLEN | Supervisor trap vector |
| inMie | input | 1 | Machine interrupt enable |
| inSie | input | 1 | Supervisor interrupt enable |
| inMpie | input | 1 | Machine previous enable |
| inSpie | input | 1 | Supervisor previous enable |
| inMpp | input | 2 | Machine previous privilege |
| inSpp | input | 1 | Supervisor previous privilege |
| excValid | input | 1 | Synchronous exception request |
| excCause | input | XLEN | Exception cause number |
| excTvalValid | input | 1 | Exception carries a faulting address |
| excTval | input | XLEN | Faulting address |
| trapFire | output | 1 | Trap accepted last cycle |
| trapToSuper | output | 1 | Last trap went to supervisor |
| nextPc | output | XLEN | Trap handler PC |
| privOut | output | 2 | Privilege after the trap |
| stMie | output | 1 | Updated machine interrupt enable |
| stSie | output | 1 | Updated supervisor interrupt enable |
| stMpie | output | 1 | Updated machine previous enable |
| stSpie | output | 1 | Updated supervisor previous enable |
| stMpp | output | 2 | Updated machine previous privilege |
| stSpp | output | 1 | Updated supervisor previous privilege |
| mepcOut | output | XLEN | Machine exception PC |
| mcauseOut | output | XLEN | Machine cause |
| mtvalOut | output | XLEN | Machine bad address |
| sepcOut | output | XLEN | Supervisor exception PC |
| scauseOut | output | XLEN | Supervisor cause |
| stvalOut | output | XLEN | Supervisor bad address |

## Verification
On every cycle the assertions check the status-stack rules of both trap levels and the one-cycle relation between a request and `trapFire`. They also check that an exception always fires with a non-interrupt cause, that an interrupt cannot be taken in machine mode with machine interrupts disabled, and that bad-address registers stay unchanged on traps that carry no address. Whether the right interrupt wins, whether delegation picks the right level, and the exact vectored PC can only be shown by the bench scenarios. These are a table of hand-worked cases plus a sweep of every privilege against delegation and enable combinations, scored against a reference model.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef logic [1:0] priv_t;

  localparam priv_t PRIV_U = 2'b00;
  localparam priv_t PRIV_S = 2'b01;
  localparam priv_t PRIV_M = 2'b11;

  // Strobes from the arbitration control to the state datapath.
  typedef struct packed {
    logic fire;     // a trap is accepted this cycle
    logic toSuper;  // handled at supervisor level
    logic isIrq;    // the trap is an interrupt
    logic wrBad;    // faulting address must be recorded
  } trap_strobe_t;

endpackage

// File: rtl/trap_prio.sv
module trap_prio #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]         req,
  output logic                     any,
  output logic [$clog2(WIDTH)-1:0] idx
);
  localparam int IDX_W = $clog2(WIDTH);

  logic [WIDTH:0]   seen;
  logic [WIDTH-1:0] first;

  assign seen[0] = 1'b0;

  // Prefix-OR chain isolates the lowest set request bit.
  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      assign first[g]    = req[g] & ~seen[g];
      assign seen[g + 1] = seen[g] | req[g];
    end
  endgenerate

  assign any = seen[WIDTH];

  always_comb begin
    idx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (first[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  priv_t             curPriv,
  input  logic [XLEN-1:0]   irqPending,
  input  logic [XLEN-1:0]   midelegIn,
  input  logic [XLEN-1:0]   medelegIn,
  input  logic              inMie,
  input  logic              inSie,
  input  logic              excValid,
  input  logic [XLEN-1:0]   excCause,
  input  logic              excTvalValid,
  output trap_strobe_t      strobe,
  output logic [XLEN-1:0]   causeIdx
);
  localparam int IDX_W = $clog2(XLEN);
  localparam logic [XLEN-1:0] IDX_LIMIT = XLEN'(XLEN);

  logic            mLevelOn;
  logic            sLevelOn;
  logic [XLEN-1:0] mCand;
  logic [XLEN-1:0] sCand;
  logic [XLEN-1:0] eligible;
  logic            irqAny;
  logic [IDX_W-1:0] irqIdx;
  logic            takeIrq;
  logic            takeAny;
  logic [XLEN-1:0] delegVec;
  logic            idxInRange;
  logic            goSuper;

  // Stage one: undelegated interrupts under the machine enable rule.
  always_comb begin
    mLevelOn = (curPriv < PRIV_M) || inMie;
    sLevelOn = (curPriv < PRIV_S) || ((curPriv == PRIV_S) && inSie);
    mCand    = irqPending & ~midelegIn & {XLEN{mLevelOn}};
    sCand    = irqPending &  midelegIn & {XLEN{sLevelOn}};
    // Stage two only when stage one found nothing.
    eligible = (|mCand) ? mCand : sCand;
  end

  trap_prio #(.WIDTH(XLEN)) u_prio (
    .req (eligible),
    .any (irqAny),
    .idx (irqIdx)
  );

  always_comb begin
    takeIrq    = !excValid && irqAny;
    takeAny    = excValid || irqAny;
    causeIdx   = excValid ? excCause : {{(XLEN-IDX_W){1'b0}}, irqIdx};
    delegVec   = takeIrq ? midelegIn : medelegIn;
    idxInRange = causeIdx < IDX_LIMIT;
    goSuper    = takeAny && (curPriv <= PRIV_S) && idxInRange
                 && delegVec[causeIdx[IDX_W-1:0]];
  end

  always_comb begin
    strobe.fire    = takeAny;
    strobe.toSuper = goSuper;
    strobe.isIrq   = takeIrq;
    strobe.wrBad   = excValid && excTvalValid;
  end
endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  trap_strobe_t      strobe,
  input  logic [XLEN-1:0]   causeIdx,
  input  priv_t             curPriv,
  input  logic [XLEN-1:0]   curPc,
  input  logic [XLEN-1:0]   mtvecIn,
  input  logic [XLEN-1:0]   stvecIn,
  input  logic              inMie,
  input  logic              inSie,
  input  logic              inMpie,
  input  logic              inSpie,
  input  priv_t             inMpp,
  input  logic              inSpp,
  input  logic [XLEN-1:0]   excTval,
  output logic              trapFire,
  output logic              trapToSuper,
  output logic [XLEN-1:0]   nextPc,
  output priv_t             privOut,
  output logic              stMie,
  output logic              stSie,
  output logic              stMpie,
  output logic              stSpie,
  output priv_t             stMpp,
  output logic              stSpp,
  output logic [XLEN-1:0]   mepcOut,
  output logic [XLEN-1:0]   mcauseOut,
  output logic [XLEN-1:0]   mtvalOut,
  output logic [XLEN-1:0]   sepcOut,
  output logic [XLEN-1:0]   scauseOut,
  output logic [XLEN-1:0]   stvalOut
);
  logic [XLEN-1:0] causeWord;
  logic [XLEN-1:0] mtvecBase;
  logic [XLEN-1:0] vecOffset;
  logic [XLEN-1:0] machinePc;

  always_comb begin
    causeWord = {causeIdx[XLEN-1] | strobe.isIrq, causeIdx[XLEN-2:0]};
    mtvecBase = {mtvecIn[XLEN-1:1], 1'b0};
    vecOffset = (mtvecIn[0] && strobe.isIrq) ? {causeIdx[XLEN-3:0], 2'b00} : '0;
    machinePc = mtvecBase + vecOffset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapFire    <= 1'b0;
      trapToSuper <= 1'b0;
      nextPc      <= '0;
      privOut     <= PRIV_M;
      stMie       <= 1'b0;
      stSie       <= 1'b0;
      stMpie      <= 1'b0;
      stSpie      <= 1'b0;
      stMpp       <= PRIV_U;
      stSpp       <= 1'b0;
      mepcOut     <= '0;
      mcauseOut   <= '0;
      mtvalOut    <= '0;
      sepcOut     <= '0;
      scauseOut   <= '0;
      stvalOut    <= '0;
    end else begin
      trapFire <= strobe.fire;
      if (strobe.fire) begin
        trapToSuper <= strobe.toSuper;
        if (strobe.toSuper) begin
          nextPc    <= stvecIn;
          privOut   <= PRIV_S;
          stSpie    <= inSie;
          stSpp     <= curPriv[0];
          stSie     <= 1'b0;
          stMie     <= inMie;
          stMpie    <= inMpie;
          stMpp     <= inMpp;
          sepcOut   <= curPc;
          scauseOut <= causeWord;
          if (strobe.wrBad) stvalOut <= excTval;
        end else begin
          nextPc    <= machinePc;
          privOut   <= PRIV_M;
          stMpie    <= inMie;
          stMpp     <= curPriv;
          stMie     <= 1'b0;
          stSie     <= inSie;
          stSpie    <= inSpie;
          stSpp     <= inSpp;
          mepcOut   <= curPc;
          mcauseOut <= causeWord;
          if (strobe.wrBad) mtvalOut <= excTval;
        end
      end
    end
  end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      curPriv,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] irqPending,
  input  logic [XLEN-1:0] midelegIn,
  input  logic [XLEN-1:0] medelegIn,
  input  logic [XLEN-1:0] mtvecIn,
  input  logic [XLEN-1:0] stvecIn,
  input  logic            inMie,
  input  logic            inSie,
  input  logic            inMpie,
  input  logic            inSpie,
  input  logic [1:0]      inMpp,
  input  logic            inSpp,
  input  logic            excValid,
  input  logic [XLEN-1:0] excCause,
  input  logic            excTvalValid,
  input  logic [XLEN-1:0] excTval,
  output logic            trapFire,
  output logic            trapToSuper,
  output logic [XLEN-1:0] nextPc,
  output logic [1:0]      privOut,
  output logic            stMie,
  output logic            stSie,
  output logic            stMpie,
  output logic            stSpie,
  output logic [1:0]      stMpp,
  output logic            stSpp,
  output logic [XLEN-1:0] mepcOut,
  output logic [XLEN-1:0] mcauseOut,
  output logic [XLEN-1:0] mtvalOut,
  output logic [XLEN-1:0] sepcOut,
  output logic [XLEN-1:0] scauseOut,
  output logic [XLEN-1:0] stvalOut
);
  trap_strobe_t    strobe;
  logic [XLEN-1:0] causeIdx;

  trap_ctrl #(.XLEN(XLEN)) u_ctrl (
    .curPriv      (curPriv),
    .irqPending   (irqPending),
    .midelegIn    (midelegIn),
    .medelegIn    (medelegIn),
    .inMie        (inMie),
    .inSie        (inSie),
    .excValid     (excValid),
    .excCause     (excCause),
    .excTvalValid (excTvalValid),
    .strobe       (strobe),
    .causeIdx     (causeIdx)
  );

  trap_dp #(.XLEN(XLEN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .causeIdx    (causeIdx),
    .curPriv     (curPriv),
    .curPc       (curPc),
    .mtvecIn     (mtvecIn),
    .stvecIn     (stvecIn),
    .inMie       (inMie),
    .inSie       (inSie),
    .inMpie      (inMpie),
    .inSpie      (inSpie),
    .inMpp       (inMpp),
    .inSpp       (inSpp),
    .excTval     (excTval),
    .trapFire    (trapFire),
    .trapToSuper (trapToSuper),
    .nextPc      (nextPc),
    .privOut     (privOut),
    .stMie       (stMie),
    .stSie       (stSie),
    .stMpie      (stMpie),
    .stSpie      (stSpie),
    .stMpp       (stMpp),
    .stSpp       (stSpp),
    .mepcOut     (mepcOut),
    .mcauseOut   (mcauseOut),
    .mtvalOut    (mtvalOut),
    .sepcOut     (sepcOut),
    .scauseOut   (scauseOut),
    .stvalOut    (stvalOut)
  );
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      curPriv,
  input logic [XLEN-1:0] irqPending,
  input logic [XLEN-1:0] mtvecIn,
  input logic            inMie,
  input logic            inSie,
  input logic            excValid,
  input logic            excTvalValid,
  input logic            trapFire,
  input logic            trapToSuper,
  input logic [XLEN-1:0] nextPc,
  input logic [1:0]      privOut,
  input logic            stMie,
  input logic            stSie,
  input logic            stMpie,
  input logic            stSpie,
  input logic [1:0]      stMpp,
  input logic            stSpp,
  input logic [XLEN-1:0] mcauseOut,
  input logic [XLEN-1:0] scauseOut,
  input logic [XLEN-1:0] mtvalOut,
  input logic [XLEN-1:0] stvalOut
);
  // R4: an exception always fires next cycle with a non-interrupt cause
  p_exc_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> (trapFire && (trapToSuper ? !scauseOut[XLEN-1] : !mcauseOut[XLEN-1])));

  // R1: machine mode with machine enable clear takes no interrupt
  p_m_masked_r1: assert property (@(posedge clk) disable iff (!rstN)
    (curPriv == 2'b11 && !inMie && !excValid) |=> !trapFire);

  // R5: supervisor traps only from user or supervisor
  p_super_origin_r5: assert property (@(posedge clk) disable iff (!rstN)
    (trapFire && trapToSuper) |-> ($past(curPriv) <= 2'b01));

  // R6: supervisor status stack
  p_super_stack_r6: assert property (@(posedge clk) disable iff (!rstN)
    (trapFire && trapToSuper) |->
      (privOut == 2'b01 && !stSie && stSpie == $past(inSie) && stSpp == $past(curPriv[0])));

  // R8: machine status stack
  p_mach_stack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (trapFire && !trapToSuper) |->
      (privOut == 2'b11 && !stMie && stMpie == $past(inMie) && stMpp == $past(curPriv)));

  // R7: direct mode lands on the base
  p_direct_pc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (trapFire && !trapToSuper && !$past(mtvecIn[0])) |->
      (nextPc == {$past(mtvecIn[XLEN-1:1]), 1'b0}));

  // R9: no faulting address recorded, bad-address registers hold
  p_bad_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(excValid && excTvalValid) |-> ($stable(mtvalOut) && $stable(stvalOut)));

  // R10: no request, no pulse
  p_no_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && irqPending == '0) |=> !trapFire);
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/trap_unit_bench.sv
module trap_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XL = 32;
  localparam logic [31:0] MTVEC_BASE = 32'h0000_1000;
  localparam logic [31:0] STVEC_VAL  = 32'h0000_2000;
  localparam logic [31:0] PC_VAL     = 32'h0000_0400;

  typedef struct packed {
    logic [1:0]  priv;
    logic [31:0] pend;
    logic [31:0] mid;
    logic [31:0] med;
    logic        mie;
    logic        sie;
    logic        exc;
    logic [31:0] ecause;
    logic        vec;
    logic        expFire;
    logic        expSup;
    logic [31:0] expCause;
    logic [31:0] expPc;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t TABLE [NVEC] = '{
    '{2'd3, 32'h80, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 32'd0, 1'b0, 1'b1, 1'b0, 32'h8000_0007, 32'h1000},
    '{2'd3, 32'h80, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 32'h8000_0007, 32'h101C},
    '{2'd3, 32'h80, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 32'h0,        32'h0},
    '{2'd0, 32'h22, 32'h2, 32'h0, 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0, 32'h8000_0005, 32'h1014},
    '{2'd0, 32'h02, 32'h2, 32'h0, 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b1, 1'b1, 32'h8000_0001, 32'h2000},
    '{2'd1, 32'h02, 32'h2, 32'h0, 1'b1, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 32'h0,        32'h0},
    '{2'd1, 32'h02, 32'h2, 32'h0, 1'b0, 1'b1, 1'b0, 32'd0, 1'b0, 1'b1, 1'b1, 32'h8000_0001, 32'h2000},
    '{2'd3, 32'h00, 32'h0, 32'h4, 1'b1, 1'b0, 1'b1, 32'd2, 1'b1, 1'b1, 1'b0, 32'd2,        32'h1000},
    '{2'd0, 32'h80, 32'h0, 32'h2000, 1'b1, 1'b0, 1'b1, 32'd13, 1'b1, 1'b1, 1'b1, 32'd13,   32'h2000},
    '{2'd1, 32'h00, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, 32'd40, 1'b0, 1'b1, 1'b0, 32'd40, 32'h1000},
    '{2'd3, 32'h88, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 32'd0, 1'b0, 1'b1, 1'b0, 32'h8000_0003, 32'h1000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] curPriv;
  logic [31:0] curPc, irqPending, midelegIn, medelegIn, mtvecIn, stvecIn;
  logic inMie, inSie, inMpie, inSpie, inSpp, excValid, excTvalValid;
  logic [1:0] inMpp;
  logic [31:0] excCause, excTval;
  logic trapFire, trapToSuper, stMie, stSie, stMpie, stSpie, stSpp;
  logic [1:0] privOut, stMpp;
  logic [31:0] nextPc, mepcOut, mcauseOut, mtvalOut, sepcOut, scauseOut, stvalOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_unit #(.XLEN(XL)) u_trap_unit (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic [31:0] pend, mid, med,
                       input logic mieB, sieB, exc, input logic [31:0] ecause,
                       input logic tvV, input logic [31:0] tv, input logic vec);
    curPriv = p; irqPending = pend; midelegIn = mid; medelegIn = med;
    inMie = mieB; inSie = sieB; excValid = exc; excCause = ecause;
    excTvalValid = tvV; excTval = tv; mtvecIn = MTVEC_BASE | {31'b0, vec};
  endtask

  task automatic idle();
    irqPending = '0; excValid = 1'b0; excTvalValid = 1'b0;
  endtask

  // Reference model of arbitration, delegation and handler PC.
  task automatic refModel(input logic [1:0] p, input logic [31:0] pend, mid, med,
                          input logic mieB, sieB, exc, input logic [31:0] ecause,
                          input logic vec, output logic fire, output logic sup,
                          output logic [31:0] cause, output logic [31:0] pc);
    logic mOn, sOn, irq;
    logic [31:0] mc, sc, el, idx, dl;
    mOn = (p != 2'd3) || mieB;
    sOn = (p == 2'd0) || (p == 2'd1 && sieB);
    mc = pend & ~mid & {32{mOn}};
    sc = pend & mid & {32{sOn}};
    el = (mc != 0) ? mc : sc;
    idx = 0;
    for (int i = 31; i >= 0; i--) if (el[i]) idx = i;
    irq = !exc && (el != 0);
    fire = exc || (el != 0);
    if (exc) idx = ecause;
    dl = irq ? mid : med;
    sup = fire && (p <= 2'd1) && (idx < 32) && dl[idx[4:0]];
    cause = irq ? (32'h8000_0000 | idx) : idx;
    pc = sup ? STVEC_VAL : (MTVEC_BASE + ((vec && irq) ? (idx << 2) : 32'h0));
  endtask

  // Drive one request, sample at the next falling edge.
  task automatic runCase(input string tag, input logic [1:0] p, input logic [31:0] pend, mid, med,
                         input logic mieB, sieB, exc, input logic [31:0] ecause, input logic vec);
    logic fire, sup;
    logic [31:0] cause, pc;
    refModel(p, pend, mid, med, mieB, sieB, exc, ecause, vec, fire, sup, cause, pc);
    drive(p, pend, mid, med, mieB, sieB, exc, ecause, 1'b0, 32'h0, vec);
    @(negedge clk);
    check({tag, " R1 R2 fire"}, {31'b0, trapFire}, {31'b0, fire});
    if (fire) begin
      check({tag, " R5 level"}, {31'b0, trapToSuper}, {31'b0, sup});
      check({tag, " R7 pc"}, nextPc, pc);
      if (sup) begin
        check({tag, " R6 cause"}, scauseOut, cause);
        check({tag, " R6 epc"}, sepcOut, PC_VAL);
        check({tag, " R6 stack"}, {22'b0, privOut, stSie, stSpie, stSpp, stMie, stMpie, stMpp},
              {22'b0, 2'b01, 1'b0, sieB, p[0], mieB, inMpie, inMpp});
      end else begin
        check({tag, " R8 cause"}, mcauseOut, cause);
        check({tag, " R8 epc"}, mepcOut, PC_VAL);
        check({tag, " R8 stack"}, {22'b0, privOut, stMie, stMpie, stMpp, stSie, stSpie, stSpp},
              {22'b0, 2'b11, 1'b0, mieB, p, sieB, inSpie, inSpp});
      end
    end
    idle();
  endtask

  initial begin
    logic [31:0] holdPc;
    curPc = PC_VAL; stvecIn = STVEC_VAL;
    inMpie = 1'b1; inSpie = 1'b0; inMpp = 2'b01; inSpp = 1'b1;
    drive(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 trapFire", {31'b0, trapFire}, 32'h0);
    check("R11 privOut", {30'b0, privOut}, 32'h3);
    check("R11 mcause", mcauseOut, 32'h0);
    check("R11 nextPc", nextPc, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Hand-worked table (R3 priority, R4 precedence, R7 vectoring)
    for (int k = 0; k < NVEC; k++) begin
      vec_t v;
      v = TABLE[k];
      drive(v.priv, v.pend, v.mid, v.med, v.mie, v.sie, v.exc, v.ecause, 1'b0, 32'h0, v.vec);
      @(negedge clk);
      check($sformatf("table%0d R1 R2 fire", k), {31'b0, trapFire}, {31'b0, v.expFire});
      if (v.expFire) begin
        check($sformatf("table%0d R5 level", k), {31'b0, trapToSuper}, {31'b0, v.expSup});
        check($sformatf("table%0d R3 R4 cause", k), v.expSup ? scauseOut : mcauseOut, v.expCause);
        check($sformatf("table%0d R7 pc", k), nextPc, v.expPc);
      end
      idle();
    end

    // Sweep: privilege x delegation x enables against the model
    for (int pi = 0; pi < 3; pi++) begin
      for (int dm = 0; dm < 4; dm++) begin
        for (int en = 0; en < 4; en++) begin
          logic [1:0] p;
          logic [31:0] mid;
          p = (pi == 2) ? 2'd3 : 2'(pi);
          mid = (dm[1] ? 32'h20 : 32'h0) | (dm[0] ? 32'h2 : 32'h0);
          runCase("sweep", p, 32'h22, mid, 32'h0, en[0], en[1], 1'b0, 32'd0, 1'b1);
        end
      end
      runCase("sweepExc", (pi == 2) ? 2'd3 : 2'(pi), 32'h0, 32'h0, 32'h4, 1'b1, 1'b1, 1'b1, 32'd2, 1'b0);
      runCase("sweepExcND", (pi == 2) ? 2'd3 : 2'(pi), 32'h22, 32'h0, 32'h0, 1'b1, 1'b1, 1'b1, 32'd2, 1'b1);
    end

    // R9 bad-address handling
    drive(2'd3, 0, 0, 0, 1, 0, 1, 32'd5, 1'b1, 32'hDEAD_0000, 1'b0);
    @(negedge clk);
    check("R9 mtval written", mtvalOut, 32'hDEAD_0000);
    check("R9 stval untouched", stvalOut, 32'h0);
    idle();
    drive(2'd3, 0, 0, 0, 1, 0, 1, 32'd5, 1'b0, 32'h0000_1234, 1'b0);
    @(negedge clk);
    check("R9 mtval no address", mtvalOut, 32'hDEAD_0000);
    idle();
    drive(2'd3, 32'h8, 0, 0, 1, 0, 0, 32'd0, 1'b1, 32'h5555_5555, 1'b0);
    @(negedge clk);
    check("R9 irq fired", {31'b0, trapFire}, 32'h1);
    check("R9 irq no address", mtvalOut, 32'hDEAD_0000);
    idle();
    holdPc = 32'h0;
    drive(2'd0, 0, 0, 32'h20, 0, 0, 1, 32'd5, 1'b1, 32'h0000_BEEF, 1'b0);
    curPc = 32'h0000_0800;
    @(negedge clk);
    check("R9 stval written", stvalOut, 32'h0000_BEEF);
    check("R9 mtval other level", mtvalOut, 32'hDEAD_0000);
    check("R10 mepc held on super trap", mepcOut, PC_VAL);
    check("R6 sepc", sepcOut, 32'h0000_0800);
    idle();
    holdPc = nextPc;
    @(negedge clk);
    // R10 single pulse and hold
    check("R10 pulse ends", {31'b0, trapFire}, 32'h0);
    check("R10 pc held", nextPc, holdPc);
    check("R10 stval held", stvalOut, 32'h0000_BEEF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule